// File: doc/BRIEF.md
# Shared Slave Port Arbiter with Slot Limit

This block decides which of several bus masters may drive one shared slave port. All of it runs on one clock. Each master raises a request while it wants the port, and it pulses a burst-end line on the last beat of its access. The arbiter answers with a one-hot grant, the index of the connected master and a connected flag.

A slot timer counts the cycles since the last arbitration. Once a master has held the port for the programmed number of cycles and another master is waiting, the timer forces a handover. A separate break input forces the same handover at once. In both cases the block marks the break with a one-cycle strobe.

When no request is pending, the port rests according to a park policy. It can drop every master, stay with the last user, or connect to a programmed fixed master. Which policy is chosen decides whether the next access pays one cycle of grant latency. The three configuration fields (slot limit, park policy and fixed index) load on a write strobe, and a write-protect input blocks that load.

Top module: `slv_port_arb`

## Requirements
- R1: After reset the port is disconnected, no grant is active and the break strobe is low. The configuration resets to slot limit 0, park code 0 and fixed index 0, and master 0 is taken as the previous winner.
- R2: While the port is connected, the grant vector has exactly one bit set, at the position given by the owner index, and the connected flag is high. While the port is disconnected, the grant vector is all zero.
- R3: On a disconnected port, a request first seen before a clock edge is granted after that edge and not before it. This is the one extra cycle of latency.
- R4: At an arbitration point the winner is the first requesting master found by searching upward from the previous owner index plus one, modulo the master count. The previous owner itself is searched last.
- R5: Without slot expiry or a break, an owner keeps the port until it pulses its burst-end line or drops its request. A burst-end pulse rearbitrates over all requests without raising the break strobe.
- R6: With slot limit S not 0, an owner that keeps requesting while another master waits holds the grant for exactly S consecutive cycles. The grant then moves to the next waiting master, and the break strobe is high for exactly the first cycle of the new grant.
- R7: A slot limit of 0 turns the slot timer off. An owner then keeps the port for any number of cycles, and the break strobe stays low.
- R8: A break input pulse hands the port to the next waiting master after the next edge and raises the break strobe in that cycle. A break pulse has no effect when no other master is requesting.
- R9: Park code 0, and the reserved code 3, disconnect the port one edge after the owner goes idle with no request pending.
- R10: Park code 1 keeps an idle port connected to its last owner. That owner's new request therefore already holds the grant in the cycle it is raised. Another master's request takes the port after one edge.
- R11: Park code 2 connects an idle port, whether disconnected or connected, to the master whose index is in the fixed field after one edge. A fixed index not below the master count makes code 2 behave as code 0.
- R12: On an edge where the write strobe is high and write protect is low, all three configuration fields load. When write protect is high, the write is ignored and the old configuration stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_MST | Per-master request |
| last_i | input | N_MST | Per-master burst-end pulse (last beat of the access) |
| brk_i | input | 1 | Forced break of the current burst |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wp_i | input | 1 | Write protect; blocks configuration writes when high |
| cfg_slot_i | input | SLOT_W | Slot limit in cycles, 0 turns the timer off |
| cfg_park_i | input | 2 | Park code: 0 none, 1 last owner, 2 fixed master, 3 none |
| cfg_fix_i | input | $clog2(N_MST)+1 | Fixed park master index |
| gnt_o | output | N_MST | One-hot grant |
| own_o | output | $clog2(N_MST) | Index of the current or last owner |
| own_vld_o | output | 1 | Port connected to own_o |
| brk_o | output | 1 | One-cycle strobe marking a broken burst |

## Verification
Some behaviours are checked by assertions on every cycle:
- a wake-up grant always goes to a master that was requesting;
- a busy owner is never preempted without a slot expiry or a break;
- a slot expiry moves the port and raises the strobe;
- a zero slot limit never raises the strobe;
- each park policy lands on the expected state;
- protected writes leave the configuration unchanged.

Other behaviours only the directed scenarios can show. These are the exact S-cycle hold length, the round-robin order over several request patterns, the zero-latency grant of a parked master, the out-of-range fallback of the fixed index, and the fact that a protected write leaves the earlier slot limit working.

// File: rtl/slv_arb_pkg.sv
package slv_arb_pkg;

  // Park policy after decoding the two-bit configuration code.
  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2
  } park_e;

  // Code 3 is reserved and acts as "none". Code 2 with an unusable index
  // also acts as "none".
  function automatic park_e park_decode(logic [1:0] code, logic fixed_ok);
    park_e p;
    case (code)
      2'd1:    p = PARK_LAST;
      2'd2:    p = fixed_ok ? PARK_FIXED : PARK_NONE;
      default: p = PARK_NONE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/slv_arb_cfg.sv
module slv_arb_cfg #(
  parameter int SLOT_W = 8,
  parameter int FIX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              wp_i,
  input  logic [SLOT_W-1:0] slot_d_i,
  input  logic [1:0]        park_d_i,
  input  logic [FIX_W-1:0]  fix_d_i,
  output logic [SLOT_W-1:0] slot_q_o,
  output logic [1:0]        park_q_o,
  output logic [FIX_W-1:0]  fix_q_o
);

  logic wr_accept;
  assign wr_accept = we_i & ~wp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q_o <= '0;
      park_q_o <= '0;
      fix_q_o  <= '0;
    end else if (wr_accept) begin
      slot_q_o <= slot_d_i;
      park_q_o <= park_d_i;
      fix_q_o  <= fix_d_i;
    end
  end

  // R12: a protected write leaves every field as it was
  a_r12_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wp_i) |=> ($stable(slot_q_o) && $stable(park_q_o) && $stable(fix_q_o)));

  // R12: an unprotected write loads the presented values
  a_r12_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wp_i) |=> (slot_q_o == $past(slot_d_i) && park_q_o == $past(park_d_i)
                         && fix_q_o == $past(fix_d_i)));

endmodule

// File: rtl/slv_arb_slot.sv
module slv_arb_slot #(
  parameter int SLOT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              run_i,
  input  logic [SLOT_W-1:0] limit_i,
  output logic              expired_o
);

  localparam logic [SLOT_W-1:0] CNT_MAX = {SLOT_W{1'b1}};

  logic [SLOT_W-1:0] cnt_q;

  // cnt counts the cycles since the grant was loaded, starting at 0 in the
  // first granted cycle. The slot is spent in the cycle where cnt+1 reaches
  // the limit.
  function automatic logic slot_done(logic [SLOT_W-1:0] cnt, logic [SLOT_W-1:0] lim);
    logic [SLOT_W:0] used;
    used = {1'b0, cnt} + {{SLOT_W{1'b0}}, 1'b1};
    return (lim != '0) && (used >= {1'b0, lim});
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (run_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = slot_done(cnt_q, limit_i);

endmodule

// File: rtl/slv_arb_select.sv
module slv_arb_select #(
  parameter int N_MST = 4,
  parameter int IDX_W = 2
) (
  input  logic [N_MST-1:0] cands_i,
  input  logic [IDX_W-1:0] prev_i,
  output logic [IDX_W-1:0] win_o,
  output logic             any_o
);

  // Search upward from prev+1, wrapping around, so that prev comes last.
  always_comb begin
    win_o = '0;
    any_o = 1'b0;
    for (int k = 1; k <= N_MST; k++) begin
      int j;
      j = (int'(prev_i) + k) % N_MST;
      if (!any_o && cands_i[j]) begin
        win_o = IDX_W'(j);
        any_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/slv_port_arb.sv
module slv_port_arb
  import slv_arb_pkg::*;
#(
  parameter int N_MST  = 4,
  parameter int SLOT_W = 8,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1,
  localparam int FIX_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_MST-1:0]  req_i,
  input  logic [N_MST-1:0]  last_i,
  input  logic              brk_i,
  input  logic              cfg_we_i,
  input  logic              cfg_wp_i,
  input  logic [SLOT_W-1:0] cfg_slot_i,
  input  logic [1:0]        cfg_park_i,
  input  logic [FIX_W-1:0]  cfg_fix_i,
  output logic [N_MST-1:0]  gnt_o,
  output logic [IDX_W-1:0]  own_o,
  output logic              own_vld_o,
  output logic              brk_o
);

  // configuration
  logic [SLOT_W-1:0] slot_q;
  logic [1:0]        park_code_q;
  logic [FIX_W-1:0]  fix_q;

  slv_arb_cfg #(.SLOT_W(SLOT_W), .FIX_W(FIX_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wp_i     (cfg_wp_i),
    .slot_d_i (cfg_slot_i),
    .park_d_i (cfg_park_i),
    .fix_d_i  (cfg_fix_i),
    .slot_q_o (slot_q),
    .park_q_o (park_code_q),
    .fix_q_o  (fix_q)
  );

  // owner state
  logic             conn_q, conn_d;
  logic [IDX_W-1:0] own_q, own_d;
  logic             brk_q, brk_d;
  logic             restart;

  logic [N_MST-1:0] own_oh;
  logic [N_MST-1:0] others;
  logic             any_req;
  logic             fixed_ok;
  park_e            park;
  logic [IDX_W-1:0] fix_idx;

  assign own_oh   = {{(N_MST-1){1'b0}}, 1'b1} << own_q;
  assign others   = req_i & ~own_oh;
  assign any_req  = |req_i;
  assign fixed_ok = int'(fix_q) < N_MST;
  assign park     = park_decode(park_code_q, fixed_ok);
  assign fix_idx  = fix_q[IDX_W-1:0];

  // named events
  logic slot_exp;
  logic own_active;
  logic own_end;
  logic own_idle;
  logic slot_cut;
  logic flag_cut;
  logic cut;

  assign own_active = conn_q & req_i[own_q];
  assign own_end    = own_active & last_i[own_q];
  assign own_idle   = conn_q & ~req_i[own_q];
  assign slot_cut   = own_active & ~own_end & slot_exp & (|others);
  assign flag_cut   = own_active & ~own_end & brk_i & (|others);
  assign cut        = slot_cut | flag_cut;

  slv_arb_slot #(.SLOT_W(SLOT_W)) u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .run_i     (conn_q),
    .limit_i   (slot_q),
    .expired_o (slot_exp)
  );

  // round-robin winner; on a cut the owner is excluded
  logic [N_MST-1:0] cands;
  logic [IDX_W-1:0] win;
  logic             win_any;

  assign cands = cut ? others : req_i;

  slv_arb_select #(.N_MST(N_MST), .IDX_W(IDX_W)) u_sel (
    .cands_i (cands),
    .prev_i  (own_q),
    .win_o   (win),
    .any_o   (win_any)
  );

  // next owner
  always_comb begin
    conn_d  = conn_q;
    own_d   = own_q;
    brk_d   = 1'b0;
    restart = 1'b0;
    if (!conn_q) begin
      if (win_any) begin
        own_d   = win;
        conn_d  = 1'b1;
        restart = 1'b1;
      end else if (park == PARK_FIXED) begin
        own_d   = fix_idx;
        conn_d  = 1'b1;
        restart = 1'b1;
      end
    end else if (cut) begin
      own_d   = win;
      brk_d   = 1'b1;
      restart = 1'b1;
    end else if (own_end || own_idle) begin
      if (win_any) begin
        own_d   = win;
        restart = 1'b1;
      end else begin
        case (park)
          PARK_FIXED: begin
            own_d   = fix_idx;
            restart = 1'b1;
          end
          PARK_LAST: begin
            own_d = own_q;
          end
          default: begin
            conn_d = 1'b0;
          end
        endcase
      end
    end else if (slot_exp) begin
      restart = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_q <= 1'b0;
      own_q  <= '0;
      brk_q  <= 1'b0;
    end else begin
      conn_q <= conn_d;
      own_q  <= own_d;
      brk_q  <= brk_d;
    end
  end

  assign gnt_o     = conn_q ? own_oh : '0;
  assign own_o     = own_q;
  assign own_vld_o = conn_q;
  assign brk_o     = brk_q;

  // R3: waking from disconnect grants a master that was requesting
  a_r3_wake_to_requester: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!own_vld_o && any_req) |=> (own_vld_o && ((gnt_o & $past(req_i)) != '0)));

  // R5: a busy owner is not preempted without expiry, break or end
  a_r5_no_preempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_active && !own_end && !slot_exp && !brk_i) |=> (own_vld_o && $stable(own_o) && !brk_o));

  // R6: a slot expiry with a waiter moves the port and raises the strobe
  a_r6_slot_handover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_cut |=> (brk_o && own_vld_o && own_o != $past(own_o)));

  // R7: with the timer off and no break input, no strobe follows
  a_r7_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == '0 && !brk_i) |=> !brk_o);

  // R8: a break with a waiter moves the port
  a_r8_flag_handover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_cut |=> (brk_o && own_o != $past(own_o)));

  // R9: park none releases an idle port
  a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_idle && !any_req && park == PARK_NONE) |=> !own_vld_o);

  // R10: park last keeps an idle port on its owner
  a_r10_stay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_idle && !any_req && park == PARK_LAST) |=> (own_vld_o && $stable(own_o)));

  // R11: park fixed lands on the programmed master
  a_r11_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((own_idle || !conn_q) && !any_req && park == PARK_FIXED)
      |=> (own_vld_o && own_o == $past(fix_q[IDX_W-1:0])));

endmodule

// File: tb/test_slv_port_arb.sv
`timescale 1ns/1ps
module test_slv_port_arb;

  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic [3:0] last = '0;
  logic       brk_in = 1'b0;
  logic       we = 1'b0;
  logic       wp = 1'b0;
  logic [7:0] slot = '0;
  logic [1:0] park = '0;
  logic [2:0] fix = '0;
  logic [3:0] gnt;
  logic [1:0] own;
  logic       vld;
  logic       brk_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  slv_port_arb #(.N_MST(N), .SLOT_W(8)) i_slv_port_arb (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .last_i(last), .brk_i(brk_in),
    .cfg_we_i(we), .cfg_wp_i(wp), .cfg_slot_i(slot), .cfg_park_i(park),
    .cfg_fix_i(fix), .gnt_o(gnt), .own_o(own), .own_vld_o(vld), .brk_o(brk_out)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rr_model(logic [3:0] c, int prev);
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (prev + k) % N;
      if (c[j]) return j;
    end
    return -1;
  endfunction

  task automatic do_reset();
    req = '0; last = '0; brk_in = 0; we = 0; wp = 0;
    slot = '0; park = '0; fix = '0;
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
    tick();
  endtask

  task automatic cfg_write(int s, int p, int f, bit prot);
    slot = 8'(s); park = 2'(p); fix = 3'(f); wp = prot; we = 1;
    tick();
    we = 0; wp = 0;
  endtask

  task automatic hold_count(logic [3:0] mask, int start, output int n);
    n = start;
    while (gnt == mask && n < 60) begin
      tick();
      if (gnt == mask) n++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 grant after reset", gnt, 0);
    chk("R1 connected after reset", vld, 0);
    chk("R1 strobe after reset", brk_out, 0);
  endtask

  task automatic t_latency();
    do_reset();
    req = 4'b0010;
    chk("R3 no grant before edge", gnt, 0);
    tick();
    chk("R3 grant after one edge", gnt, 4'b0010);
    chk("R2 owner index", own, 1);
    chk("R2 connected flag", vld, 1);
    last = 4'b0010;
    tick();
    chk("R5 lone owner keeps port on end", gnt, 4'b0010);
    last = '0; req = '0;
    tick();
    chk("R9 disconnect when idle", gnt, 0);
    chk("R2 flag low when disconnected", vld, 0);
  endtask

  task automatic t_round_robin();
    int e;
    do_reset();
    req = 4'hF;
    e = rr_model(4'hF, 0);
    tick();
    chk("R4 first winner all requesting", own, e);
    for (int i = 0; i < 6; i++) begin
      last = 4'(1 << e);
      tick();
      e = rr_model(4'hF, e);
      chk("R4 rotation all requesting", own, e);
      chk("R5 no strobe on end handover", brk_out, 0);
    end
    for (int i = 0; i < 3; i++) begin
      req = 4'b1001;
      last = 4'(1 << e);
      tick();
      e = rr_model(4'b1001, e);
      chk("R4 rotation pattern 1001", own, e);
    end
    last = '0; req = '0;
    tick();
  endtask

  task automatic t_slot_limit();
    int n;
    do_reset();
    cfg_write(5, 0, 0, 0);
    req = 4'b0001;
    tick();
    chk("R6 first owner", gnt, 4'b0001);
    req = 4'b0101;
    hold_count(4'b0001, 1, n);
    chk("R6 hold length master 0", n, 5);
    chk("R6 handover to master 2", gnt, 4'b0100);
    chk("R6 strobe on handover", brk_out, 1);
    tick();
    chk("R6 strobe lasts one cycle", brk_out, 0);
    hold_count(4'b0100, 2, n);
    chk("R6 hold length master 2", n, 5);
    chk("R6 handover back to master 0", gnt, 4'b0001);
    req = '0;
    tick();
  endtask

  task automatic t_slot_off();
    int bad;
    bad = 0;
    do_reset();
    req = 4'b0001;
    tick();
    req = 4'b0101;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (gnt != 4'b0001 || brk_out != 0) bad++;
    end
    chk("R7 owner kept with timer off", bad, 0);
    last = 4'b0001;
    tick();
    last = '0;
    chk("R5 end hands over", gnt, 4'b0100);
    chk("R5 end handover strobe low", brk_out, 0);
    req = '0;
    tick();
  endtask

  task automatic t_break_flag();
    do_reset();
    req = 4'b0001;
    tick();
    brk_in = 1;
    tick();
    brk_in = 0;
    chk("R8 break ignored without waiter", gnt, 4'b0001);
    chk("R8 no strobe without waiter", brk_out, 0);
    req = 4'b0101; brk_in = 1;
    tick();
    brk_in = 0;
    chk("R8 break hands over", gnt, 4'b0100);
    chk("R8 strobe on break", brk_out, 1);
    req = '0;
    tick();
  endtask

  task automatic t_park_last();
    do_reset();
    cfg_write(0, 1, 0, 0);
    req = 4'b0010;
    tick();
    chk("R10 grant", gnt, 4'b0010);
    req = '0;
    tick(); tick(); tick();
    chk("R10 stays on last owner", gnt, 4'b0010);
    req = 4'b0010;
    chk("R10 zero latency for parked owner", gnt, 4'b0010);
    tick();
    req = 4'b1000;
    tick();
    chk("R10 other master takes port", gnt, 4'b1000);
    req = '0;
    tick();
  endtask

  task automatic t_park_fixed();
    do_reset();
    cfg_write(0, 2, 3, 0);
    tick();
    chk("R11 parks on fixed master", gnt, 4'b1000);
    req = 4'b0001;
    tick();
    chk("R11 requester wins from park", gnt, 4'b0001);
    req = '0;
    tick();
    chk("R11 returns to fixed master", gnt, 4'b1000);
    cfg_write(0, 2, 5, 0);
    tick();
    chk("R11 out of range index disconnects", vld, 0);
  endtask

  task automatic t_reserved();
    do_reset();
    cfg_write(0, 3, 1, 0);
    tick();
    chk("R9 reserved code idle disconnected", vld, 0);
    req = 4'b0100;
    tick();
    chk("R9 reserved code grant", gnt, 4'b0100);
    req = '0;
    tick();
    chk("R9 reserved code releases", vld, 0);
  endtask

  task automatic t_protect();
    int n;
    do_reset();
    cfg_write(3, 0, 0, 0);
    cfg_write(0, 2, 1, 1);
    tick(); tick();
    chk("R12 protected park write ignored", vld, 0);
    req = 4'b0011;
    tick();
    chk("R12 first winner", gnt, 4'b0010);
    hold_count(4'b0010, 1, n);
    chk("R12 earlier slot limit kept", n, 3);
    chk("R12 handover after limit", gnt, 4'b0001);
    chk("R12 strobe after limit", brk_out, 1);
    req = '0;
    tick();
  endtask

  initial begin
    #(4 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_round_robin();
    t_slot_limit();
    t_slot_off();
    t_break_flag();
    t_park_last();
    t_park_fixed();
    t_reserved();
    t_protect();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule